// File: doc/BRIEF.md
# Digital Slew-Rate Limiter

This block sits in front of a 16-bit DAC code register. It does not pass a newly written target code straight to the converter. Instead it walks the output code toward the target in fixed increments, one increment per update tick. The designer chooses the increment from a table of power-of-two sizes, from 1 to 256 LSBs. The tick rate comes from a table of update rates that runs from 64,000 down to 0.5 updates per second. A prescaler counts system clocks to produce the tick, and the clock frequency is a parameter.

With slewing switched off, the block is a plain register that loads the target on the strobe. With slewing switched on, each tick moves the output one increment closer to the target. When the remaining gap is no larger than one increment, the output lands exactly on the target. A new target that arrives mid-ramp continues from wherever the output currently is, and the direction may reverse. A `ramping` flag tells the surrounding logic that the output has not yet settled.

Top module: `slew_ramp`

## Requirements
- R1: After reset, `out_code` is 0 and `ramping` is 0.
- R2: With `cfg_en` = 0, `out_code` equals the `tgt_code` presented with `tgt_vld` from the first clock edge after the strobe, and `ramping` stays 0.
- R3: `cfg_step` code k in 0..8 selects an increment of 2^k LSBs; codes 9..15 select 256 LSBs. No tick moves `out_code` by more than one increment.
- R4: `cfg_rate` code r selects the update rate from the table 64000, 32000, 16000, 8000, 4000, 2000, 1000, 500, 250, 125, 64, 32, 16, 8, 4, 0.5 per second (r = 0 to 15 in that order). The tick period is CLK_HZ / rate clock cycles (P). The first step occurs P edges after the strobe edge, and later steps follow every P edges.
- R5: When slewing is on, the output never passes the target, and it ends exactly on the target code. This includes targets at 0 and 0xFFFF.
- R6: A target strobed mid-ramp restarts the ramp from the present `out_code`. The ramp reverses direction if the new target lies on the other side.
- R7: `ramping` is 1 exactly while `out_code` differs from the last accepted target. It falls on the edge at which the output reaches the target.
- R8: Clearing `cfg_en` mid-ramp makes `out_code` take the last accepted target on the next edge.
- R9: A strobe restarts the prescaler. No step is taken on the strobe edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | 1 = slew toward target, 0 = load directly |
| cfg_rate | input | 4 | Update-rate code (R4 table) |
| cfg_step | input | 4 | Increment-size code (R3) |
| tgt_vld | input | 1 | Strobe: accept `tgt_code` this cycle |
| tgt_code | input | 16 | New target code |
| out_code | output | 16 | Current output code |
| ramping | output | 1 | Output has not yet reached the target |

## Verification
The bench first measures the distance to the first step in cycles, at a short rate and at a long rate. A prescaler that was not restarted by the strobe, or that was off by one, would show up as a step one tick early or late. It then drives step codes above 8 and makes gaps that are not multiples of the increment. A decoder that wrapped around would move by 1 instead of 256. Clamping that went wrong would overshoot the target or oscillate around it. The bench also reverses direction mid-ramp and ramps to both ends of the code range. A design that kept the old start point, or whose add overflowed, would jump or wrap instead of stepping. Finally, it clears the enable mid-ramp to confirm that the output snaps to the target rather than freezing where it is.

// File: rtl/slew_pkg.sv
package slew_pkg;
   localparam int unsigned TOP_RATE_HZ = 64000;

   // Clock cycles between update ticks for a rate code; never less than 1.
   function automatic longint rate_period(longint clk_hz, int code);
      longint p;
      if (code <= 9)
         p = (clk_hz / TOP_RATE_HZ) << code;
      else if (code == 15)
         p = clk_hz * 2;
      else
         p = clk_hz >> (16 - code);
      if (p < 1)
         p = 1;
      return p;
   endfunction
endpackage

// File: rtl/slew_tick_gen.sv
module slew_tick_gen #(
   parameter int CLK_HZ = 1000000,
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   input  logic              restart,
   output logic              tick
);
   localparam int CNT_W = $clog2(2 * CLK_HZ + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] period_m1;

   always_comb begin
      period_m1 = CNT_W'(slew_pkg::rate_period(longint'(CLK_HZ), int'(rate)) - 64'd1);
   end

   assign tick = (cnt_q == '0) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || cnt_q == '0)
         cnt_q <= period_m1;
      else
         cnt_q <= cnt_q - 1'b1;
   end

   // R9: after a restart with a period above one cycle, no tick on the next cycle
   assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && period_m1 != '0) |=> !tick);
endmodule

// File: rtl/slew_step_dec.sv
module slew_step_dec #(
   parameter int CODE_W        = 16,
   parameter int STEP_CODE_W   = 4,
   parameter int MAX_STEP_CODE = 8
) (
   input  logic [STEP_CODE_W-1:0] code,
   output logic [CODE_W-1:0]      step
);
   localparam logic [STEP_CODE_W-1:0] MAX_C = STEP_CODE_W'(MAX_STEP_CODE);

   generate
      if (MAX_STEP_CODE >= CODE_W) begin : g_bad_max
         $error("MAX_STEP_CODE must be below CODE_W");
      end
      if ((1 << STEP_CODE_W) - 1 > MAX_STEP_CODE) begin : g_sat
         always_comb begin
            if (code > MAX_C)
               step = CODE_W'(1) << MAX_STEP_CODE;
            else
               step = CODE_W'(1) << code;
         end
      end else begin : g_plain
         always_comb step = CODE_W'(1) << code;
      end
   endgenerate

   // R3: exactly one bit set in the decoded increment
   always_comb begin
      assert_step_onehot_R3: assert ($countones(step) == 1);
   end
endmodule

// File: rtl/slew_ramp.sv
module slew_ramp #(
   parameter int CODE_W        = 16,
   parameter int CLK_HZ        = 1000000,
   parameter int RATE_W        = 4,
   parameter int STEP_CODE_W   = 4,
   parameter int MAX_STEP_CODE = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_en,
   input  logic [RATE_W-1:0]      cfg_rate,
   input  logic [STEP_CODE_W-1:0] cfg_step,
   input  logic                   tgt_vld,
   input  logic [CODE_W-1:0]      tgt_code,
   output logic [CODE_W-1:0]      out_code,
   output logic                   ramping
);
   generate
      if (RATE_W != 4) begin : g_bad_rate
         $error("rate table needs RATE_W of 4");
      end
      if (CLK_HZ < int'(slew_pkg::TOP_RATE_HZ)) begin : g_bad_clk
         $error("CLK_HZ must reach the fastest update rate");
      end
   endgenerate

   logic [CODE_W-1:0] cur_q, tgt_q, step_sz, gap, nxt_move;
   logic              tick, upward, near;

   slew_tick_gen #(.CLK_HZ(CLK_HZ), .RATE_W(RATE_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .rate(cfg_rate), .restart(tgt_vld), .tick(tick)
   );

   slew_step_dec #(.CODE_W(CODE_W), .STEP_CODE_W(STEP_CODE_W),
                   .MAX_STEP_CODE(MAX_STEP_CODE)) u_step (
      .code(cfg_step), .step(step_sz)
   );

   always_comb begin
      upward   = tgt_q > cur_q;
      gap      = upward ? (tgt_q - cur_q) : (cur_q - tgt_q);
      near     = gap <= step_sz;
      nxt_move = near ? tgt_q : (upward ? cur_q + step_sz : cur_q - step_sz);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         tgt_q <= '0;
      end else begin
         if (tgt_vld)
            tgt_q <= tgt_code;
         if (!cfg_en)
            cur_q <= tgt_vld ? tgt_code : tgt_q;
         else if (tick && cur_q != tgt_q)
            cur_q <= nxt_move;
      end
   end

   assign out_code = cur_q;
   assign ramping  = cur_q != tgt_q;

   // R2: bypass loads the strobed code on the next edge
   assert_bypass_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && tgt_vld) |=> (out_code == $past(tgt_code)));
   // R5: no overshoot going up or down
   assert_no_overshoot_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !tgt_vld && cur_q < tgt_q) |=> (cur_q <= tgt_q));
   assert_no_overshoot_dn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !tgt_vld && cur_q > tgt_q) |=> (cur_q >= tgt_q));
   // R4: output holds between ticks when slewing
   assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !tick) |=> $stable(cur_q));
   // R7: a settled output stays settled until a new target arrives
   assert_settled_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ramping && !tgt_vld && cfg_en) |=> !ramping);
endmodule

// File: tb/slew_ramp_tb.sv
module slew_ramp_tb;
   localparam int CLK_HZ = 128000;

   logic        clk = 0, rst_n = 0;
   logic        cfg_en = 0, tgt_vld = 0;
   logic [3:0]  cfg_rate = 0, cfg_step = 0;
   logic [15:0] tgt_code = 0;
   wire  [15:0] out_code;
   wire         ramping;

   int checks = 0, errors = 0;
   string tag = "R1";

   slew_ramp #(.CLK_HZ(CLK_HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_rate(cfg_rate),
      .cfg_step(cfg_step), .tgt_vld(tgt_vld), .tgt_code(tgt_code),
      .out_code(out_code), .ramping(ramping)
   );

   always #5 clk = ~clk;

   function automatic int period_of(int code);
      real rate;
      if (code == 15) rate = 0.5;
      else if (code <= 9) rate = 64000.0 / (2.0 ** code);
      else rate = 2.0 ** (16 - code);
      return int'(CLK_HZ / rate);
   endfunction

   function automatic int step_of(int code);
      return (code > 8) ? 256 : (1 << code);
   endfunction

   // behavioural reference
   int m_cur = 0, m_tgt = 0, m_cnt = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cur = 0; m_tgt = 0; m_cnt = 0;
      end else begin
         automatic int  p    = period_of(int'(cfg_rate));
         automatic int  s    = step_of(int'(cfg_step));
         automatic bit  tk   = (m_cnt == 0) && !tgt_vld;
         automatic int  otgt = m_tgt;
         if (tgt_vld || m_cnt == 0) m_cnt = p - 1; else m_cnt = m_cnt - 1;
         if (tgt_vld) m_tgt = int'(tgt_code);
         if (!cfg_en) m_cur = tgt_vld ? int'(tgt_code) : otgt;
         else if (tk && m_cur != otgt) begin
            if (otgt > m_cur) m_cur = (otgt - m_cur <= s) ? otgt : m_cur + s;
            else              m_cur = (m_cur - otgt <= s) ? otgt : m_cur - s;
         end
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(tag, int'(out_code), m_cur);
         check("R7", int'(ramping), int'(m_cur != m_tgt));
      end
   end

   task automatic strobe(int v);
      @(negedge clk); tgt_vld = 1; tgt_code = 16'(v);
      @(negedge clk); tgt_vld = 0;
   endtask

   task automatic cfg(bit en, int rate, int step);
      @(negedge clk); cfg_en = en; cfg_rate = 4'(rate); cfg_step = 4'(step);
   endtask

   task automatic measure(string req, int exp_n, int exp_delta);
      automatic int start = int'(out_code);
      automatic int n = 0;
      while (int'(out_code) == start && n < 5000) begin
         @(negedge clk); n++;
      end
      check({req, " cycles"}, n, exp_n);
      check({req, " delta"}, int'(out_code) - start, exp_delta);
   endtask

   task automatic settle(int tgt);
      automatic int n = 0;
      while (ramping && n < 60000) begin
         @(negedge clk); n++;
      end
      check("R5 landed", int'(out_code), tgt);
      check("R7 flag low", int'(ramping), 0);
   endtask

   initial begin
      automatic int v;
      repeat (3) @(negedge clk);
      check("R1 out", int'(out_code), 0);
      check("R1 ramping", int'(ramping), 0);
      rst_n = 1;

      tag = "R2";
      strobe(16'h1234);
      check("R2 load", int'(out_code), 16'h1234);
      check("R2 flag", int'(ramping), 0);

      tag = "R4";
      cfg(1, 3, 2);
      strobe(16'h1234 + 40);
      measure("R4 rate3", 16, 4);
      settle(16'h1234 + 40);

      tag = "R3";
      cfg(1, 0, 12);
      v = int'(out_code) - 1000;
      strobe(v);
      measure("R3 clamp code", 2, -256);
      settle(v);

      tag = "R5";
      cfg(1, 1, 0);
      v = int'(out_code) + 5;
      strobe(v);
      settle(v);

      tag = "R6";
      cfg(1, 0, 3);
      strobe(int'(out_code) + 200);
      repeat (10) @(negedge clk);
      v = int'(out_code) - 50;
      strobe(v);
      measure("R6 reverse", 2, -8);
      settle(v);

      tag = "R8";
      cfg(1, 2, 0);
      v = int'(out_code) + 300;
      strobe(v);
      repeat (20) @(negedge clk);
      @(negedge clk); cfg_en = 0;
      @(negedge clk);
      check("R8 snap", int'(out_code), v);

      tag = "R5";
      strobe(16'hFF00);
      cfg(1, 0, 8);
      strobe(16'hFFFF);
      settle(16'hFFFF);
      cfg(1, 0, 7);
      strobe(0);
      settle(0);

      tag = "R4";
      cfg(1, 9, 0);
      strobe(1);
      measure("R4 rate9", 1024, 1);

      tag = "R9";
      cfg(1, 1, 0);
      strobe(100);
      measure("R9 restart", 4, 1);
      settle(100);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule